// File: doc/BRIEF.md
# GPIO Input Bank Interrupt Condition Detector

This block serves a bank of general-purpose pins (16 by default) and watches every input for four conditions: a low-to-high transition, a high-to-low transition, a high level and a low level. Each condition has its own per-pin enable register and its own per-pin pending register. A pending bit latches whenever its condition is seen on a pin whose input enable is set, whether or not the interrupt is enabled. Software clears pending bits by writing ones to them. Each pin drives a dedicated interrupt line to an external interrupt controller. That line is high while at least one condition on the pin is both pending and enabled.

A simple 32-bit register bus reads and writes the bank. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from the addressed register. Pin inputs pass through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier. The block also holds the output-enable and output-value registers, plus an invert mask that is applied to the output value on its way to the pins.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, every register reads 0 and `pin_irq`, `pin_out` and `pin_oe` are all 0.
- R2: Offset 0x00 reads the synchronised pin level ANDed with the input-enable register (0x04). Bit i is pin i. Writes to 0x00 have no effect.
- R3: `pin_oe` equals the register at 0x08. `pin_out` equals the value register at 0x0C XOR the invert register at 0x40.
- R4: The rise-pending register (0x1C) sets bit i on a 0-to-1 change of enabled pin i. The fall-pending register (0x24) sets bit i on a 1-to-0 change.
- R5: The high-pending register (0x2C) and the low-pending register (0x34) set bit i in every cycle that enabled pin i sits at that level.
- R6: Pending bits latch even when the matching interrupt enable is 0. A pin whose input enable is 0 never sets any pending bit.
- R7: `pin_irq[i]` is 1 exactly when, for some condition, both the pending bit i and the enable bit i are 1. The enables are rise 0x18, fall 0x20, high 0x28 and low 0x30.
- R8: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. A level that is still present keeps its pending bit at 1.
- R9: When a condition event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R10: Several conditions on one pin may be pending at the same time, each independent of the others.
- R11: Reads of unmapped offsets (for example 0x14, 0x3C, 0x44) return 0. Writes to them change no register.
- R12: Each pin has its own interrupt line. A condition on pin i affects only `pin_irq[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of addressed register |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_oe | output | 16 | Output enable per pin |
| pin_out | output | 16 | Output value per pin |
| pin_irq | output | 16 | Interrupt line per pin |

## Verification
The collision that matters is a condition event meeting a write-1-to-clear of the same pending bit on the same edge. The bench provokes it by changing a pin and then placing the clearing write on exactly the edge where the synchronised rising edge is latched. It counts the synchroniser and previous-value stages to find that edge. The bit must read back as 1, and a second, quiet clear must then bring it to 0. A held level meeting a clear is covered the same way: the bit must stay set.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 7;
    localparam int REG_WORD_W = ADDR_W - 2;
    localparam int NUM_COND   = 4;

    // Order matters: the condition index sets the register word pair.
    typedef enum logic [1:0] {
        COND_RISE = 2'd0,
        COND_FALL = 2'd1,
        COND_HIGH = 2'd2,
        COND_LOW  = 2'd3
    } cond_e;

    localparam logic [REG_WORD_W-1:0] W_LEVEL   = REG_WORD_W'(0);
    localparam logic [REG_WORD_W-1:0] W_IN_EN   = REG_WORD_W'(1);
    localparam logic [REG_WORD_W-1:0] W_OUT_EN  = REG_WORD_W'(2);
    localparam logic [REG_WORD_W-1:0] W_OUT_VAL = REG_WORD_W'(3);
    localparam logic [REG_WORD_W-1:0] W_OUT_INV = REG_WORD_W'(16);
    localparam int                    COND_BASE = 6;

    typedef struct packed {
        logic                  wr_hit;
        logic [REG_WORD_W-1:0] word;
        logic [DATA_W-1:0]     data;
    } bus_req_t;

    function automatic logic [REG_WORD_W-1:0] cond_en_word(input int unsigned c);
        return REG_WORD_W'(COND_BASE + 2 * c);
    endfunction

    function automatic logic [REG_WORD_W-1:0] cond_pend_word(input int unsigned c);
        return REG_WORD_W'(COND_BASE + 2 * c + 1);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur = sync_q;
    assign prv = prev_q;
endmodule

// File: rtl/gpio_cond_detect.sv
module gpio_cond_detect
    import gpio_evt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]                cur,
    input  logic [W-1:0]                prv,
    input  logic [W-1:0]                ien,
    output logic [NUM_COND-1:0][W-1:0]  evt
);
    for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
        if (c == int'(COND_RISE)) begin : g_rise
            assign evt[c] = cur & ~prv & ien;
        end else if (c == int'(COND_FALL)) begin : g_fall
            assign evt[c] = ~cur & prv & ien;
        end else if (c == int'(COND_HIGH)) begin : g_high
            assign evt[c] = cur & ien;
        end else begin : g_low
            assign evt[c] = ~cur & ien;
        end
    end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bus_req_t                      req,
    input  logic [PINS-1:0]               level,
    input  logic [NUM_COND-1:0][PINS-1:0] evt,
    output logic [DATA_W-1:0]             rdata,
    output logic [PINS-1:0]               ien,
    output logic [PINS-1:0]               oe,
    output logic [PINS-1:0]               oval,
    output logic [PINS-1:0]               oinv,
    output logic [NUM_COND-1:0][PINS-1:0] cen,
    output logic [NUM_COND-1:0][PINS-1:0] cpend
);
    logic [PINS-1:0]               wbits;
    logic [NUM_COND-1:0][PINS-1:0] clr;

    assign wbits = req.data[PINS-1:0];

    always_comb begin
        for (int c = 0; c < NUM_COND; c++) begin
            clr[c] = (req.wr_hit && req.word == cond_pend_word(c)) ? wbits : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien   <= '0;
            oe    <= '0;
            oval  <= '0;
            oinv  <= '0;
            cen   <= '0;
            cpend <= '0;
        end else begin
            if (req.wr_hit) begin
                if (req.word == W_IN_EN)   ien  <= wbits;
                if (req.word == W_OUT_EN)  oe   <= wbits;
                if (req.word == W_OUT_VAL) oval <= wbits;
                if (req.word == W_OUT_INV) oinv <= wbits;
            end
            for (int c = 0; c < NUM_COND; c++) begin
                if (req.wr_hit && req.word == cond_en_word(c)) cen[c] <= wbits;
                // event applied after the clear: a same-cycle event survives
                cpend[c] <= (cpend[c] & ~clr[c]) | evt[c];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (req.word == W_LEVEL)   rdata = DATA_W'(level & ien);
        if (req.word == W_IN_EN)   rdata = DATA_W'(ien);
        if (req.word == W_OUT_EN)  rdata = DATA_W'(oe);
        if (req.word == W_OUT_VAL) rdata = DATA_W'(oval);
        if (req.word == W_OUT_INV) rdata = DATA_W'(oinv);
        for (int c = 0; c < NUM_COND; c++) begin
            if (req.word == cond_en_word(c))   rdata = DATA_W'(cen[c]);
            if (req.word == cond_pend_word(c)) rdata = DATA_W'(cpend[c]);
        end
    end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_irq
);
    bus_req_t                      req;
    logic [PINS-1:0]               cur_lvl, prv_lvl;
    logic [PINS-1:0]               ien_q, oval_q, oinv_q;
    logic [NUM_COND-1:0][PINS-1:0] cond_evt, cond_en, cond_pend;

    assign req.wr_hit = bus_sel & bus_wr;
    assign req.word   = bus_addr[ADDR_W-1:2];
    assign req.data   = bus_wdata;

    gpio_in_sync #(.W(PINS)) sync_i (
        .clk (clk),
        .rst (rst),
        .raw (pin_in),
        .cur (cur_lvl),
        .prv (prv_lvl)
    );

    gpio_cond_detect #(.W(PINS)) det_i (
        .cur (cur_lvl),
        .prv (prv_lvl),
        .ien (ien_q),
        .evt (cond_evt)
    );

    gpio_evt_regs #(.PINS(PINS)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .level (cur_lvl),
        .evt   (cond_evt),
        .rdata (bus_rdata),
        .ien   (ien_q),
        .oe    (pin_oe),
        .oval  (oval_q),
        .oinv  (oinv_q),
        .cen   (cond_en),
        .cpend (cond_pend)
    );

    assign pin_out = oval_q ^ oinv_q;

    always_comb begin
        pin_irq = '0;
        for (int c = 0; c < NUM_COND; c++) begin
            pin_irq = pin_irq | (cond_en[c] & cond_pend[c]);
        end
    end
endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk
    import gpio_evt_pkg::*;
#(
    parameter int PINS = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [PINS-1:0]               pin_irq,
    input logic [PINS-1:0]               ien,
    input logic [NUM_COND-1:0][PINS-1:0] cen,
    input logic [NUM_COND-1:0][PINS-1:0] cpend,
    input logic [NUM_COND-1:0][PINS-1:0] evt
);
    logic [REG_WORD_W-1:0] word;
    logic                  mapped;
    logic [PINS-1:0]       any_en, any_pend;

    assign word   = bus_addr[ADDR_W-1:2];
    assign mapped = (word <= 5'd3) || (word >= 5'd6 && word <= 5'd13) || (word == 5'd16);
    assign any_en   = cen[0] | cen[1] | cen[2] | cen[3];
    assign any_pend = cpend[0] | cpend[1] | cpend[2] | cpend[3];

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == '0);

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_irq & ~any_en) == '0);

    // R7
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_irq & ~any_pend) == '0);

    for (genvar c = 0; c < NUM_COND; c++) begin : g_c
        // R9
        event_latch_chk: assert property (@(posedge clk) disable iff (rst)
            (evt[c] != '0) |=> ((cpend[c] & $past(evt[c])) == $past(evt[c])));

        // R8
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_wr && word == cond_pend_word(c) &&
             (evt[c] & bus_wdata[PINS-1:0]) == '0)
            |=> (cpend[c] & $past(bus_wdata[PINS-1:0])) == '0);

        // R6
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            ((cpend[c] & ~$past(cpend[c])) & ~$past(ien)) == '0);
    end
endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.PINS(PINS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_irq   (pin_irq),
    .ien       (ien_q),
    .cen       (cond_en),
    .cpend     (cond_pend),
    .evt       (cond_evt)
);

// File: tb/gpio_evt_bank_tb_top.sv
module gpio_evt_bank_tb_top;
    localparam int PINS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe, pin_out, pin_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_evt_bank #(.PINS(PINS)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_irq(pin_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic clear_all_pending();
        bus_write(7'h1C, 32'hFFFF);
        bus_write(7'h24, 32'hFFFF);
        bus_write(7'h2C, 32'hFFFF);
        bus_write(7'h34, 32'hFFFF);
    endtask

    task automatic t_reset();
        logic [6:0] regs [13] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h18, 7'h1C, 7'h20,
                                  7'h24, 7'h28, 7'h2C, 7'h30, 7'h34, 7'h40};
        for (int i = 0; i < 13; i++) read_check("R1 reg after reset", regs[i], 32'h0);
        @(negedge clk);
        check("R1 irq after reset", 32'(pin_irq), 32'h0);
        check("R1 out after reset", 32'(pin_out), 32'h0);
        check("R1 oe after reset", 32'(pin_oe), 32'h0);
    endtask

    task automatic t_outputs();
        bus_write(7'h08, 32'h00F0);
        bus_write(7'h0C, 32'h1234);
        bus_write(7'h40, 32'h00FF);
        @(negedge clk);
        check("R3 pin_oe", 32'(pin_oe), 32'h00F0);
        check("R3 pin_out xor", 32'(pin_out), 32'h12CB);
        read_check("R3 invert readback", 7'h40, 32'h00FF);
    endtask

    task automatic t_input();
        pin_in = 16'hA5A5;
        bus_write(7'h04, 32'h00FF);
        wait_clk(3);
        read_check("R2 level masked by input enable", 7'h00, 32'h00A5);
    endtask

    task automatic t_edges();
        @(negedge clk); pin_in = 16'h0000;
        bus_write(7'h04, 32'hFFFF);
        wait_clk(4);
        clear_all_pending();
        wait_clk(1);
        read_check("R4 rise cleared", 7'h1C, 32'h0);
        read_check("R8 held low level re-latched", 7'h34, 32'hFFFF);
        @(negedge clk); pin_in = 16'h0003;
        wait_clk(4);
        read_check("R4 rise pending", 7'h1C, 32'h0003);
        read_check("R4 no fall yet", 7'h24, 32'h0);
        read_check("R5 high pending", 7'h2C, 32'h0003);
        @(negedge clk);
        check("R6 latched while disabled, irq low", 32'(pin_irq), 32'h0);
        @(negedge clk); pin_in = 16'h0001;
        wait_clk(4);
        read_check("R4 fall pending", 7'h24, 32'h0002);
        read_check("R10 high stays latched", 7'h2C, 32'h0003);
        read_check("R10 rise stays latched", 7'h1C, 32'h0003);
        read_check("R5 low pending", 7'h34, 32'hFFFF);
    endtask

    task automatic t_w1c();
        bus_write(7'h1C, 32'h0001);
        read_check("R8 write one clears only that bit", 7'h1C, 32'h0002);
        bus_write(7'h24, 32'h0000);
        read_check("R8 write zero leaves bits", 7'h24, 32'h0002);
        bus_write(7'h2C, 32'hFFFF);
        read_check("R8 present high level stays", 7'h2C, 32'h0001);
    endtask

    task automatic t_irq();
        bus_write(7'h18, 32'h0002);
        check("R12 only pin1 irq", 32'(pin_irq), 32'h0002);
        bus_write(7'h18, 32'h0000);
        bus_write(7'h28, 32'h0004);
        check("R7 enabled but not pending", 32'(pin_irq), 32'h0);
        bus_write(7'h28, 32'h0001);
        bus_write(7'h30, 32'h8000);
        check("R7 high and low enables", 32'(pin_irq), 32'h8001);
        bus_write(7'h28, 32'h0);
        bus_write(7'h30, 32'h0);
        check("R7 irq drops with enables", 32'(pin_irq), 32'h0);
    endtask

    task automatic t_disabled();
        bus_write(7'h04, 32'h0);
        wait_clk(1);
        clear_all_pending();
        @(negedge clk); pin_in = 16'h00F0;
        wait_clk(4);
        read_check("R6 no rise when input disabled", 7'h1C, 32'h0);
        read_check("R6 no high when input disabled", 7'h2C, 32'h0);
        read_check("R6 no low when input disabled", 7'h34, 32'h0);
        read_check("R2 disabled pins read zero", 7'h00, 32'h0);
    endtask

    task automatic t_coincide();
        bus_write(7'h04, 32'h0100);
        wait_clk(3);
        bus_write(7'h1C, 32'hFFFF);
        @(negedge clk); pin_in = 16'h01F0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 7'h1C; bus_wdata = 32'h0100;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        read_check("R9 event wins over clear", 7'h1C, 32'h0100);
        bus_write(7'h1C, 32'h0100);
        read_check("R8 quiet clear", 7'h1C, 32'h0);
    endtask

    task automatic t_unmapped();
        bus_write(7'h14, 32'hFFFF_FFFF);
        bus_write(7'h44, 32'hFFFF_FFFF);
        bus_write(7'h00, 32'hFFFF_FFFF);
        read_check("R11 unmapped 0x14", 7'h14, 32'h0);
        read_check("R11 unmapped 0x44", 7'h44, 32'h0);
        read_check("R11 unmapped 0x3C", 7'h3C, 32'h0);
        read_check("R11 input enable untouched", 7'h04, 32'h0100);
        read_check("R11 out value untouched", 7'h0C, 32'h1234);
        read_check("R2 level write ignored", 7'h00, 32'h0100);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait_clk(3);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_outputs();
        t_input();
        t_edges();
        t_w1c();
        t_irq();
        t_disabled();
        t_coincide();
        t_unmapped();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule